// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of an SDRAM interface. It owns the command pins from reset until the memory is ready for normal traffic. It keeps clock enable and the data mask high and first waits a stabilization pause, sized in clock cycles from a clock frequency parameter. It then closes every bank with a precharge-all and programs the mode register from three configuration inputs: CAS latency, wrap type and burst length. It also issues a programmable number of auto refreshes, never fewer than two. Each command is followed by the wait that the memory demands. Between steps the pins carry NOP.

A parameter sets whether the mode register is written before or after the refresh train. When the final wait has run out, `init_done` rises and stays high, and the pins keep NOP so that the normal scheduler can take over. The configuration inputs are plain static pins: they are sampled in the cycle in which the mode word is driven and must be stable by then. There is no streaming data path, so the block has no valid/ready handshake.

Cycle numbering used below: edge 1 is the first rising clock edge with `rst_n` high. "A command at edge k" means that the pins show it from edge k until edge k+1. Command codes are given as {cs_n, ras_n, cas_n, we_n}.

Top module: `sdram_powerup_seq`

## Requirements
- R1: `sd_cke` is 1 during reset and in every cycle after it.
- R2: Outside the command cycles, the pins show NOP (code 0111), with `sd_addr` and `sd_bank` all zero. This holds during reset, between steps and after completion.
- R3: No command other than NOP appears before edge PAUSE_CYC = PAUSE_US*CLK_MHZ. The first command appears at exactly that edge.
- R4: `sd_dqm` is 1 from reset through the precharge cycle, and 0 from the following edge onward.
- R5: The first command is precharge-all (code 0010) with `sd_addr[10]`=1, all other address bits 0 and bank 0. The next command follows exactly TRP_CYC edges later.
- R6: The mode register set command (code 0000) carries burst length in `sd_addr[2:0]` (000=1, 001=2, 010=4, 011=8, 111=full page), wrap type in `sd_addr[3]` (0 sequential, 1 interleave) and CAS latency in `sd_addr[6:4]` (010=2, 011=3). `sd_addr[11:7]` and the bank bits are 0.
- R7: After mode register set, the next command (or `init_done`) comes max(TMRD_CYC,2) edges later. The cycle straight after it is always NOP.
- R8: Exactly max(REF_COUNT,2) auto refreshes (code 0001) are issued. Each one is followed by TRC_CYC edges before the next command or `init_done`.
- R9: With MRS_FIRST=1 the order is precharge, mode set, refreshes. With MRS_FIRST=0 it is precharge, refreshes, mode set.
- R10: `init_done` rises at the edge where the last command's wait ends (last command edge plus its gap), stays 1, and the pins stay NOP while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_cas_lat | input | 3 | CAS latency code for the mode word |
| cfg_wrap_il | input | 1 | Wrap type: 0 sequential, 1 interleave |
| cfg_burst_len | input | 3 | Burst length code for the mode word |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_cke | output | 1 | Clock enable to the memory |
| sd_dqm | output | 1 | Data mask / output buffer disable |
| sd_addr | output | ADDR_W | Address bus (mode word, precharge-all bit) |
| sd_bank | output | BANK_W | Bank select |
| init_done | output | 1 | High once initialization is complete |

## Verification
Two pairs of events share a clock boundary. The data mask is released on the edge right after the precharge command. `init_done` rises on the same edge that ends the final wait, where a further command would otherwise have gone out. The bench provokes both with short waits in two instances, one for each step order. One of them asks for a single refresh, so the minimum-of-two clamp is exercised. A scoreboard queue holds every expected command with its edge number, and the bench compares the mask level and `init_done` on both sides of each boundary.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // Command code as {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sdram_cmd_e;

  typedef enum logic [2:0] {
    ST_PRE  = 3'd0,
    ST_MRS  = 3'd1,
    ST_REF  = 3'd2,
    ST_DONE = 3'd3,
    ST_IDLE = 3'd4
  } step_e;

  typedef struct packed {
    logic [2:0] cas_lat;
    logic       wrap_il;
    logic [2:0] burst_len;
  } mode_fields_t;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_mode_word.sv
module sdram_mode_word
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  mode_fields_t      fields,
  output logic [ADDR_W-1:0] word
);

  // Burst length bits 2..0, wrap bit 3, CAS latency bits 6..4; rest zero.
  always_comb begin
    word      = '0;
    word[2:0] = fields.burst_len;
    word[3]   = fields.wrap_il;
    word[6:4] = fields.cas_lat;
  end

endmodule

// File: rtl/sdram_wait_timer.sv
module sdram_wait_timer #(
  parameter int CNT_W   = 8,
  parameter int RST_VAL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  assign expired = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_W'(RST_VAL);
    end else if (load) begin
      cnt_q <= load_val;
    end else if (!expired) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/sdram_step_fsm.sv
module sdram_step_fsm
  import sdram_init_pkg::*;
#(
  parameter int MRS_FIRST = 1,
  parameter int REFS      = 2,
  parameter int TRP_GAP   = 1,
  parameter int TMRD_GAP  = 2,
  parameter int TRC_GAP   = 1,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             expired,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output sdram_cmd_e       issue_cmd,
  output logic             done_set
);

  localparam int REF_W = $clog2(REFS + 1);
  localparam logic [CNT_W-1:0] TRP_LD  = CNT_W'(TRP_GAP - 1);
  localparam logic [CNT_W-1:0] TMRD_LD = CNT_W'(TMRD_GAP - 1);
  localparam logic [CNT_W-1:0] TRC_LD  = CNT_W'(TRC_GAP - 1);

  step_e            step_q, step_d;
  logic [REF_W-1:0] ref_left_q, ref_left_d;
  step_e            after_pre, after_mrs, after_refs;

  // Step order selected by parameter
  generate
    if (MRS_FIRST != 0) begin : g_mrs_first
      assign after_pre  = ST_MRS;
      assign after_mrs  = ST_REF;
      assign after_refs = ST_DONE;
    end else begin : g_ref_first
      assign after_pre  = ST_REF;
      assign after_mrs  = ST_DONE;
      assign after_refs = ST_MRS;
    end
  endgenerate

  always_comb begin
    step_d     = step_q;
    ref_left_d = ref_left_q;
    load       = 1'b0;
    load_val   = '0;
    issue_cmd  = CMD_NOP;
    done_set   = 1'b0;
    if (expired) begin
      unique case (step_q)
        ST_PRE: begin
          issue_cmd = CMD_PRE;
          load      = 1'b1;
          load_val  = TRP_LD;
          step_d    = after_pre;
        end
        ST_MRS: begin
          issue_cmd = CMD_MRS;
          load      = 1'b1;
          load_val  = TMRD_LD;
          step_d    = after_mrs;
        end
        ST_REF: begin
          issue_cmd = CMD_REF;
          load      = 1'b1;
          load_val  = TRC_LD;
          if (ref_left_q == REF_W'(1)) begin
            step_d     = after_refs;
            ref_left_d = REF_W'(REFS);
          end else begin
            ref_left_d = ref_left_q - 1'b1;
          end
        end
        ST_DONE: begin
          done_set = 1'b1;
          step_d   = ST_IDLE;
        end
        default: begin
          step_d = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q     <= ST_PRE;
      ref_left_q <= REF_W'(REFS);
    end else begin
      step_q     <= step_d;
      ref_left_q <= ref_left_d;
    end
  end

endmodule

// File: rtl/sdram_pin_driver.sv
module sdram_pin_driver
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sdram_cmd_e        issue_cmd,
  input  logic [ADDR_W-1:0] mode_word,
  input  logic              done_set,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic              sd_cke,
  output logic              sd_dqm,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [BANK_W-1:0] sd_bank,
  output logic              init_done
);

  localparam int ALL_BANKS_BIT = 10;

  sdram_cmd_e        cmd_q;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    addr_d = '0;
    if (issue_cmd == CMD_PRE) begin
      addr_d[ALL_BANKS_BIT] = 1'b1;
    end else if (issue_cmd == CMD_MRS) begin
      addr_d = mode_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= CMD_NOP;
      sd_addr   <= '0;
      sd_bank   <= '0;
      sd_cke    <= 1'b1;
      sd_dqm    <= 1'b1;
      init_done <= 1'b0;
    end else begin
      cmd_q     <= issue_cmd;
      sd_addr   <= addr_d;
      sd_bank   <= '0;
      sd_cke    <= 1'b1;
      if (cmd_q == CMD_PRE) begin
        sd_dqm <= 1'b0;
      end
      init_done <= init_done | done_set;
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

endmodule

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_MHZ   = 100,
  parameter int PAUSE_US  = 100,
  parameter int TRP_CYC   = 3,
  parameter int TMRD_CYC  = 2,
  parameter int TRC_CYC   = 9,
  parameter int REF_COUNT = 8,
  parameter int MRS_FIRST = 1,
  parameter int ADDR_W    = 12,
  parameter int BANK_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_cas_lat,
  input  logic              cfg_wrap_il,
  input  logic [2:0]        cfg_burst_len,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic              sd_cke,
  output logic              sd_dqm,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [BANK_W-1:0] sd_bank,
  output logic              init_done
);

  localparam int PAUSE_CYC = max_int(PAUSE_US * CLK_MHZ, 1);
  localparam int TRP_GAP   = max_int(TRP_CYC, 1);
  localparam int TMRD_GAP  = max_int(TMRD_CYC, 2);
  localparam int TRC_GAP   = max_int(TRC_CYC, 1);
  localparam int REFS      = max_int(REF_COUNT, 2);
  localparam int MAX_LD    = max_int(max_int(PAUSE_CYC, TRP_GAP),
                                     max_int(TMRD_GAP, TRC_GAP));
  localparam int CNT_W     = max_int($clog2(MAX_LD + 1), 1);

  mode_fields_t      fields;
  logic [ADDR_W-1:0] mode_word;
  logic              expired;
  logic              load;
  logic [CNT_W-1:0]  load_val;
  sdram_cmd_e        issue_cmd;
  logic              done_set;

  assign fields = '{cas_lat: cfg_cas_lat, wrap_il: cfg_wrap_il,
                    burst_len: cfg_burst_len};

  sdram_mode_word #(.ADDR_W(ADDR_W)) u_word (
    .fields (fields),
    .word   (mode_word)
  );

  sdram_wait_timer #(.CNT_W(CNT_W), .RST_VAL(PAUSE_CYC - 1)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .expired  (expired)
  );

  sdram_step_fsm #(
    .MRS_FIRST (MRS_FIRST),
    .REFS      (REFS),
    .TRP_GAP   (TRP_GAP),
    .TMRD_GAP  (TMRD_GAP),
    .TRC_GAP   (TRC_GAP),
    .CNT_W     (CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .expired   (expired),
    .load      (load),
    .load_val  (load_val),
    .issue_cmd (issue_cmd),
    .done_set  (done_set)
  );

  sdram_pin_driver #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue_cmd (issue_cmd),
    .mode_word (mode_word),
    .done_set  (done_set),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .sd_cke    (sd_cke),
    .sd_dqm    (sd_dqm),
    .sd_addr   (sd_addr),
    .sd_bank   (sd_bank),
    .init_done (init_done)
  );

endmodule

// File: rtl/sdram_powerup_seq_chk.sv
module sdram_powerup_seq_chk #(
  parameter int PAUSE_CYC = 1,
  parameter int ADDR_W    = 12,
  parameter int BANK_W    = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic              sd_cke,
  input logic              sd_dqm,
  input logic [ADDR_W-1:0] sd_addr,
  input logic [BANK_W-1:0] sd_bank,
  input logic              init_done
);

  logic [3:0] cmd;
  logic       pre_seen;
  int         since;

  assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_seen <= 1'b0;
      since    <= 0;
    end else begin
      if (cmd == 4'b0010) pre_seen <= 1'b1;
      if (since < PAUSE_CYC) since <= since + 1;
    end
  end

  a_r1_cke_held: assert property (@(posedge clk) disable iff (!rst_n)
    sd_cke == 1'b1);

  a_r2_nop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0111) |-> (sd_addr == '0 && sd_bank == '0));

  a_r3_pause_respected: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != 4'b0111) |-> (since >= PAUSE_CYC));

  a_r4_dqm_until_pre: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_seen |-> sd_dqm);

  a_r4_dqm_release: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0010) |=> !sd_dqm);

  a_r5_pre_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0010) |-> (sd_addr[10] && sd_bank == '0));

  a_r6_mode_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0000) |-> (sd_addr[ADDR_W-1:7] == '0 && sd_bank == '0));

  a_r7_mrs_then_nop: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0000) |=> (cmd == 4'b0111));

  a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  a_r10_done_nop: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (cmd == 4'b0111));

endmodule

bind sdram_powerup_seq sdram_powerup_seq_chk #(
  .PAUSE_CYC (PAUSE_CYC),
  .ADDR_W    (ADDR_W),
  .BANK_W    (BANK_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sd_cs_n   (sd_cs_n),
  .sd_ras_n  (sd_ras_n),
  .sd_cas_n  (sd_cas_n),
  .sd_we_n   (sd_we_n),
  .sd_cke    (sd_cke),
  .sd_dqm    (sd_dqm),
  .sd_addr   (sd_addr),
  .sd_bank   (sd_bank),
  .init_done (init_done)
);

// File: tb/sdram_powerup_seq_test.sv
module sdram_powerup_seq_test;

  localparam int PAUSE = 100;  // 1 MHz x 100 us
  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010,
                         REF = 4'b0001, MRS = 4'b0000;

  typedef struct {
    int         cyc;
    logic [3:0] cmd;
    logic [11:0] addr;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   cyc;
  int   n_checks = 0;
  int   n_errors = 0;
  bit   finished = 1'b0;

  exp_t qa[$];
  exp_t qb[$];

  logic a_cs, a_ras, a_cas, a_we, a_cke, a_dqm, a_done;
  logic b_cs, b_ras, b_cas, b_we, b_cke, b_dqm, b_done;
  logic [11:0] a_addr, b_addr;
  logic [1:0]  a_bank, b_bank;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  // Order: mode set first, three refreshes; CL=3, interleave, BL=8
  sdram_powerup_seq #(
    .CLK_MHZ(1), .PAUSE_US(100), .TRP_CYC(3), .TMRD_CYC(2),
    .TRC_CYC(7), .REF_COUNT(3), .MRS_FIRST(1)
  ) uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_cas_lat(3'b011), .cfg_wrap_il(1'b1), .cfg_burst_len(3'b011),
    .sd_cs_n(a_cs), .sd_ras_n(a_ras), .sd_cas_n(a_cas), .sd_we_n(a_we),
    .sd_cke(a_cke), .sd_dqm(a_dqm), .sd_addr(a_addr), .sd_bank(a_bank),
    .init_done(a_done)
  );

  // Order: refreshes first, one refresh asked (clamped to two); CL=2, seq, full page
  sdram_powerup_seq #(
    .CLK_MHZ(1), .PAUSE_US(100), .TRP_CYC(3), .TMRD_CYC(2),
    .TRC_CYC(7), .REF_COUNT(1), .MRS_FIRST(0)
  ) uut_swap (
    .clk(clk), .rst_n(rst_n),
    .cfg_cas_lat(3'b010), .cfg_wrap_il(1'b0), .cfg_burst_len(3'b111),
    .sd_cs_n(b_cs), .sd_ras_n(b_ras), .sd_cas_n(b_cas), .sd_we_n(b_we),
    .sd_cke(b_cke), .sd_dqm(b_dqm), .sd_addr(b_addr), .sd_bank(b_bank),
    .init_done(b_done)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic push(input bit which, input int c, input logic [3:0] cmd,
                      input logic [11:0] addr, input string tag);
    exp_t e;
    e.cyc = c; e.cmd = cmd; e.addr = addr; e.tag = tag;
    if (which) qb.push_back(e);
    else       qa.push_back(e);
  endtask

  // Scoreboard monitor: every non-NOP command must match the queue head
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [3:0] ca, cb;
      ca = {a_cs, a_ras, a_cas, a_we};
      cb = {b_cs, b_ras, b_cas, b_we};
      if (ca != NOP) begin
        if (qa.size() == 0) begin
          check(1'b0, "R3", "uut unexpected command", int'(ca), int'(NOP));
        end else begin
          exp_t e;
          e = qa.pop_front();
          check(cyc == e.cyc, e.tag, "uut command edge", cyc, e.cyc);
          check(ca == e.cmd, e.tag, "uut command code", int'(ca), int'(e.cmd));
          check(a_addr == e.addr && a_bank == 2'b00, e.tag, "uut address",
                int'({a_bank, a_addr}), int'(e.addr));
        end
      end
      if (cb != NOP) begin
        if (qb.size() == 0) begin
          check(1'b0, "R8", "uut_swap unexpected command", int'(cb), int'(NOP));
        end else begin
          exp_t e;
          e = qb.pop_front();
          check(cyc == e.cyc, e.tag, "uut_swap command edge", cyc, e.cyc);
          check(cb == e.cmd, e.tag, "uut_swap command code", int'(cb), int'(e.cmd));
          check(b_addr == e.addr && b_bank == 2'b00, e.tag, "uut_swap address",
                int'({b_bank, b_addr}), int'(e.addr));
        end
      end
      if (!a_cke || !b_cke) check(1'b0, "R1", "cke dropped", 0, 1);
    end
  end

  task automatic to_cycle(input int c);
    while (cyc != c) @(negedge clk);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    // Expected items, uut: PRE 100, MRS 103, REF 105/112/119, done 126
    push(0, PAUSE, PRE, 12'h400, "R5");
    push(0, 103, MRS, 12'h03B, "R6");
    push(0, 105, REF, 12'h000, "R7");
    push(0, 112, REF, 12'h000, "R8");
    push(0, 119, REF, 12'h000, "R8");
    // uut_swap: PRE 100, REF 103/110, MRS 117, done 119
    push(1, PAUSE, PRE, 12'h400, "R5");
    push(1, 103, REF, 12'h000, "R9");
    push(1, 110, REF, 12'h000, "R8");
    push(1, 117, MRS, 12'h027, "R9");

    repeat (3) @(posedge clk);
    @(negedge clk);
    // Reset state
    check({a_cs, a_ras, a_cas, a_we} == NOP && a_addr == 0, "R2", "reset cmd",
          int'({a_cs, a_ras, a_cas, a_we}), int'(NOP));
    check(a_cke && b_cke, "R1", "reset cke", int'(a_cke), 1);
    check(a_dqm && b_dqm, "R4", "reset dqm", int'(a_dqm), 1);
    check(!a_done && !b_done, "R10", "reset done", int'(a_done), 0);
    rst_n = 1'b1;

    to_cycle(50);
    check(a_dqm && b_dqm, "R4", "dqm during pause", int'(a_dqm), 1);
    to_cycle(PAUSE - 1);
    check({a_cs, a_ras, a_cas, a_we} == NOP, "R3", "nop before pause end",
          int'({a_cs, a_ras, a_cas, a_we}), int'(NOP));
    to_cycle(PAUSE);
    check(a_dqm && b_dqm, "R4", "dqm in precharge cycle", int'(a_dqm), 1);
    to_cycle(PAUSE + 1);
    check(!a_dqm && !b_dqm, "R4", "dqm after precharge", int'(a_dqm), 0);
    to_cycle(102);
    check({a_cs, a_ras, a_cas, a_we} == NOP && a_addr == 0 && a_bank == 0,
          "R2", "nop between steps", int'(a_addr), 0);
    to_cycle(104);
    check({a_cs, a_ras, a_cas, a_we} == NOP, "R7", "nop after mode set",
          int'({a_cs, a_ras, a_cas, a_we}), int'(NOP));
    to_cycle(118);
    check(!b_done, "R10", "uut_swap done early", int'(b_done), 0);
    to_cycle(119);
    check(b_done, "R10", "uut_swap done edge", int'(b_done), 1);
    to_cycle(125);
    check(!a_done, "R10", "uut done early", int'(a_done), 0);
    to_cycle(126);
    check(a_done, "R10", "uut done edge", int'(a_done), 1);
    to_cycle(140);
    check(a_done && b_done, "R10", "done held", int'(a_done & b_done), 1);
    check({a_cs, a_ras, a_cas, a_we} == NOP && {b_cs, b_ras, b_cas, b_we} == NOP,
          "R10", "nop after done", int'({a_cs, a_ras, a_cas, a_we}), int'(NOP));
    check(qa.size() == 0, "R8", "uut commands missing", qa.size(), 0);
    check(qb.size() == 0, "R9", "uut_swap commands missing", qb.size(), 0);
    finished = 1'b1;
    summary();
  end

  initial begin
    #20000;
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL R10 watchdog: actual=%0d expected=%0d", cyc, 140);
      summary();
    end
  end

endmodule